// File: doc/BRIEF.md
# Write Strobe and Data-Window Sequencer

This block sits on the controller side of a DDR-style memory interface. It produces the write strobe and the data-valid window for every write burst. When a write command is taken, the block waits the programmed write latency and emits a one-cycle preamble. The strobe then toggles once per clock cycle for each pair of data elements. A one-cycle postamble follows, with the strobe held high. Outside these windows the strobe and the data pins are released.

The strobe changes on half-cycles, so each clock cycle carries two phase bits for a downstream 2:1 serializer. Bit 1 is the value for the first half of the cycle and bit 0 is the value for the second half. Separate enables release the strobe pin and the data pins. A data-request pulse, one cycle ahead of each data cycle, pulls two elements from the write buffer.

A write that lands exactly one burst length (in clock cycles) after the previous accepted write joins it into a continuous strobe, with no postamble or preamble between the two. A write that arrives sooner is refused and flagged.

Top module: `wstrobe_seq`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: For a write accepted in cycle k with effective latency W, cycle k+W-1 is a preamble: `dqs_oe`=1, `dqs_ph`=2'b10 (high then low), `dq_oe`=0.
- R3: Cycles k+W through k+W+N-1 are data cycles, where N = 4 when `bl8`=1 and N = 2 when `bl8`=0. In each of them `dq_oe`=1, `dqs_oe`=1 and `dqs_ph`=2'b10, so there is one rising edge and one falling edge per cycle.
- R4: The cycle after the last data cycle is a postamble, with `dqs_oe`=1, `dqs_ph`=2'b11 and `dq_oe`=0.
- R5: In any cycle that is not a preamble, data or postamble cycle, `dqs_oe`=0, `dq_oe`=0 and `dqs_ph`=2'b00.
- R6: `data_req` is 1 exactly in the cycles that directly precede a data cycle.
- R7: A write accepted exactly N cycles after the previous accepted write (N of that earlier write) yields an unbroken run of data cycles, with no preamble or postamble between the two bursts.
- R8: A write arriving fewer than N cycles after the previous accepted write is refused. `wr_err` is 1 in the next cycle, and the refused write adds no preamble, data or postamble cycles.
- R9: The effective latency W is `wl_cfg` limited to the range 3..8: values below 3 act as 3 and values above 8 act as 8.
- R10: `wl_cfg` and `bl8` are sampled in the command cycle. Each burst keeps its own latency and length.
- R11: When the postamble of one burst and the preamble of the next fall in the same cycle (a gap of N+1), the preamble wins: `dqs_ph`=2'b10, `dqs_oe`=1, `dq_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_cmd | input | 1 | Write command, one cycle per command |
| wl_cfg | input | 4 | Write latency in cycles (clamped to 3..8) |
| bl8 | input | 1 | Burst length select: 1 = 8 elements, 0 = 4 elements |
| dqs_ph | output | 2 | Strobe values for the first half (bit 1) and second half (bit 0) of the cycle |
| dqs_oe | output | 1 | Strobe pin drive enable |
| dq_oe | output | 1 | Data pin drive enable |
| data_req | output | 1 | Fetch two elements from the write buffer for the next cycle |
| wr_err | output | 1 | Refused-write flag, one cycle after the command |

## Verification
The hardest cases to reach are the boundaries between neighbouring bursts. At a gap of exactly N the bursts must merge. At N+1 a postamble and a preamble share one cycle. Below N the second write must vanish while still raising the flag. The stimulus places commands at these exact offsets from a previous accepted write. It includes a mixed-length pair in which the gap rule depends on the earlier burst's length. The expected strobe pattern for every cycle comes from a table of data cycles that the driver fills in.

// File: rtl/wstrobe_seq.sv
module wstrobe_seq #(
  parameter int MIN_WL = 3,
  parameter int MAX_WL = 8,
  parameter int MAX_BL = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_cmd,
  input  logic [$clog2(MAX_WL+1)-1:0]  wl_cfg,
  input  logic                         bl8,
  output logic [1:0]                   dqs_ph,
  output logic                         dqs_oe,
  output logic                         dq_oe,
  output logic                         data_req,
  output logic                         wr_err
);
  localparam int WLW   = $clog2(MAX_WL+1);
  localparam int DEPTH = MAX_WL + MAX_BL/2 - 1;
  localparam int GW    = $clog2(MAX_BL/2+1) + 1;

  logic [DEPTH-1:0] due, ins;
  logic [WLW-1:0]   wl_eff;
  logic [GW-1:0]    nb, gap, last_n;
  logic             last_d, reject, accept, pre, post;

  always_comb begin
    if (wl_cfg < WLW'(MIN_WL))      wl_eff = WLW'(MIN_WL);
    else if (wl_cfg > WLW'(MAX_WL)) wl_eff = WLW'(MAX_WL);
    else                            wl_eff = wl_cfg;
  end

  assign nb     = bl8 ? GW'(MAX_BL/2) : GW'(MAX_BL/4);
  assign reject = wr_cmd && (gap < last_n);
  assign accept = wr_cmd && !reject;
  assign ins    = accept ? (((DEPTH'(1) << nb) - DEPTH'(1)) << (wl_eff - WLW'(1))) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      due    <= '0;
      gap    <= '1;
      last_n <= '0;
      last_d <= 1'b0;
      wr_err <= 1'b0;
    end else begin
      due    <= (due >> 1) | ins;
      last_d <= due[0];
      wr_err <= reject;
      if (accept) begin
        gap    <= GW'(1);
        last_n <= nb;
      end else if (gap != '1) begin
        gap <= gap + GW'(1);
      end
    end
  end

  assign pre      = !due[0] && due[1];
  assign post     = last_d && !due[0];
  assign dq_oe    = due[0];
  assign data_req = due[1];
  assign dqs_oe   = due[0] | pre | post;
  assign dqs_ph   = (due[0] || pre) ? 2'b10 : (post ? 2'b11 : 2'b00);

  AST_PRE_LEADS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (dqs_oe && !dq_oe && dqs_ph == 2'b10) |=> dq_oe);  // R2
  AST_DATA_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (dqs_oe && dqs_ph == 2'b10));  // R3
  AST_POST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dq_oe) && !data_req) |-> (dqs_oe && dqs_ph == 2'b11));  // R4
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !dqs_oe |-> (dqs_ph == 2'b00 && !dq_oe));  // R5
  AST_REQ_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |=> dq_oe);  // R6
endmodule

// File: tb/wstrobe_seq_bench.sv
module wstrobe_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_cmd = 1'b0;
  logic [3:0] wl_cfg = 4'd5;
  logic       bl8 = 1'b0;
  logic [1:0] dqs_ph;
  logic       dqs_oe, dq_oe, data_req, wr_err;

  wstrobe_seq u_wstrobe_seq (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wl_cfg(wl_cfg), .bl8(bl8),
    .dqs_ph(dqs_ph), .dqs_oe(dqs_oe), .dq_oe(dq_oe), .data_req(data_req), .wr_err(wr_err)
  );

  always #5 clk = ~clk;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    run = 1'b0;
  bit    exp_d   [0:4095];
  bit    exp_err [0:4095];
  int    last_cmd = -100;
  int    last_n = 0;
  string scen = "base";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] cycle %0d: actual=%0d expected=%0d", tag, scen, cyc, act, exp);
    end
  endtask

  // driver: issues a write now and records its expected data cycles / refusal
  task automatic issue(input int wl, input bit b8);
    int k, n, w;
    k = cyc;
    n = b8 ? 4 : 2;
    w = (wl < 3) ? 3 : ((wl > 8) ? 8 : wl);  // R9
    wl_cfg = 4'(wl);
    bl8 = b8;
    wr_cmd = 1'b1;
    if (k - last_cmd < last_n) begin
      exp_err[k+1] = 1'b1;  // R8
    end else begin
      for (int j = 0; j < n; j++) exp_d[k+w+j] = 1'b1;  // R3 R10
      last_cmd = k;
      last_n = n;
    end
    @(negedge clk);
    wr_cmd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: compares every cycle against the expectation table
  always @(negedge clk) begin
    if (rst_n && run) begin
      bit d, dn, dp, pr, po;
      string tag;
      d  = exp_d[cyc];
      dn = exp_d[cyc+1];
      dp = exp_d[cyc-1];
      pr = !d && dn;
      po = dp && !d;
      tag = d ? "R3" : (pr ? "R2" : (po ? "R4" : "R5"));
      check(tag, int'(dq_oe), int'(d));
      check(tag, int'(dqs_oe), int'(d | pr | po));
      check(tag, int'(dqs_ph), (d || pr) ? 2 : (po ? 3 : 0));  // preamble wins over postamble: R11
      check("R6", int'(data_req), int'(dn));
      check("R8", int'(wr_err), int'(exp_err[cyc]));
    end
  end

  always @(posedge clk) begin
    if (cyc == 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin exp_d[i] = 1'b0; exp_err[i] = 1'b0; end
    idle(3);
    scen = "R1";
    check("R1", int'({dqs_ph, dqs_oe, dq_oe, data_req, wr_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run = 1'b1;
    idle(3);

    scen = "single";
    issue(5, 1'b1); idle(20);
    issue(3, 1'b0); idle(20);

    scen = "R7";  // seamless chains
    issue(4, 1'b0); idle(1); issue(4, 1'b0); idle(1); issue(4, 1'b0); idle(20);
    issue(8, 1'b1); idle(3); issue(8, 1'b1); idle(25);

    scen = "R8";  // refused writes
    issue(5, 1'b1); issue(5, 1'b1); idle(1); issue(5, 1'b0); idle(20);
    issue(4, 1'b0); issue(4, 1'b0); idle(20);

    scen = "R9";  // latency clamping
    issue(0, 1'b0); idle(20);
    issue(15, 1'b1); idle(25);

    scen = "R10";  // mixed lengths; gap judged by earlier burst
    issue(6, 1'b0); idle(1); issue(6, 1'b1); idle(3); issue(6, 1'b0); idle(20);
    issue(3, 1'b1); idle(1); issue(3, 1'b0); idle(20);

    scen = "R11";  // gap of N+1
    issue(5, 1'b0); idle(2); issue(5, 1'b0); idle(20);
    issue(7, 1'b1); idle(4); issue(7, 1'b1); idle(25);

    run = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule